// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge lets a processor touch one bit of memory with a single load or store. Two address windows are decoded, each 32 MiB long. Every aligned 32-bit word inside a window stands for one bit of a byte-addressable memory behind the bridge.

A read of such a word fetches the downstream unit that holds the bit. It returns that bit in bit 0 of the response, and every other response bit is zero. A write fetches the same unit, sets or clears the one bit according to bit 0 of the store data, and writes the unit back. The write-back starts straight after the fetch, with nothing in between.

The slave side uses a valid/ready request and a one-cycle response strobe. It holds ready low for the whole transaction. The master side keeps each request asserted until the memory answers with its own ready. Memory latency can therefore be any number of cycles.

Top module: `bitband_bridge`

## Requirements
- R1: An address with bits 31:25 equal to 0x11 (0x2200_0000 to 0x23FF_FFFF) targets the region based at 0x2000_0000. An address with bits 31:25 equal to 0x21 (0x4200_0000 to 0x43FF_FFFF) targets the region based at 0x4000_0000.
- R2: The downstream address is the target base ORed with bits 24:5 of the request address. It has bit 0 cleared for halfword (size code 1) and bits 1:0 cleared for word (size code 2). Byte is size code 0. The downstream size equals the request size.
- R3: The bit index is taken from request address bits 6:2, keeping 3 bits for byte, 4 for halfword and 5 for word. The memory is little-endian on a 32-bit bus, so the bit sits at bus position 8*(downstream address bits 1:0) + index.
- R4: A read issues exactly one downstream read and no write. It answers with the selected bit in response bit 0, and response bits 31:1 are zero.
- R5: A write sets the selected bit when write-data bit 0 is 1 and clears it when that bit is 0. Write-data bits 31:1 are ignored. Every other memory bit keeps its value.
- R6: A write issues exactly one downstream read followed by exactly one downstream write to the same address and size. The write request is raised in the cycle right after the read completes.
- R7: From acceptance until the response, s_ready is low. The response strobe s_rsp_valid lasts exactly one cycle.
- R8: An address outside both windows, or a request with size code 3, gets s_rsp_err = 1 and s_rdata = 0. It causes no downstream access.
- R9: After reset, s_ready is 1 and m_valid and s_rsp_valid are 0.
- R10: While m_valid is high and m_ready is low, m_valid, m_we and m_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Request valid |
| s_ready | output | 1 | Request accepted when high together with s_valid |
| s_addr | input | 32 | Alias address |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| s_we | input | 1 | 1 for write |
| s_wdata | input | 32 | Write data, only bit 0 used |
| s_rsp_valid | output | 1 | One-cycle response strobe |
| s_rsp_err | output | 1 | Response is an error |
| s_rdata | output | 32 | Read result, 0 or 1 |
| m_valid | output | 1 | Downstream request valid |
| m_ready | input | 1 | Downstream completion |
| m_we | output | 1 | Downstream write |
| m_addr | output | 32 | Downstream byte address |
| m_size | output | 2 | Downstream access size |
| m_wdata | output | 32 | Downstream write data, little-endian lanes |
| m_rdata | input | 32 | Downstream read data, valid with m_ready |

## Verification
The downstream read request appears one cycle after acceptance. A read answers one cycle after the memory handshake. A write adds one more handshake, so it answers one cycle after the second one. A miss answers in the cycle right after acceptance. The bench memory model raises m_ready a set number of cycles after it sees m_valid, and the number varies per vector. The bench samples all outputs on the falling edge, so the response strobe is caught in its single valid cycle. In every cycle before that strobe it also confirms that s_ready stays low. The downstream memory applies byte strobes from m_size, so a wrong size or address shows up in the memory contents that are checked afterwards.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bb_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDWAIT = 2'd1,
    ST_WRWAIT = 2'd2,
    ST_RESP   = 2'd3
  } bb_state_e;
endpackage

// File: rtl/bb_win_decode.sv
module bb_win_decode #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 25,
  parameter int WIN_CNT   = 2,
  parameter logic [WIN_CNT*ADDR_W-1:0] ALIAS_BASE  = '0,
  parameter logic [WIN_CNT*ADDR_W-1:0] TARGET_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] tgt_base
);
  logic [WIN_CNT-1:0]       win_hit;
  logic [ADDR_W-1:0]        win_tgt [WIN_CNT];

  genvar w;
  generate
    for (w = 0; w < WIN_CNT; w++) begin : g_win
      localparam logic [ADDR_W-1:0] ABASE = ALIAS_BASE[w*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] TBASE = TARGET_BASE[w*ADDR_W +: ADDR_W];
      assign win_hit[w] = (addr[ADDR_W-1:SPAN_LOG2] == ABASE[ADDR_W-1:SPAN_LOG2]);
      assign win_tgt[w] = win_hit[w] ? TBASE : '0;
    end
  endgenerate

  always_comb begin
    tgt_base = '0;
    for (int i = 0; i < WIN_CNT; i++) tgt_base = tgt_base | win_tgt[i];
  end

  assign hit = |win_hit;
endmodule

// File: rtl/bb_addr_map.sv
module bb_addr_map #(
  parameter int ADDR_W    = 32,
  parameter int SPAN_LOG2 = 25,
  parameter int DATA_W    = 32
) (
  input  logic [ADDR_W-1:0]             tgt_base,
  input  logic [SPAN_LOG2-1:0]          offset,
  input  logic [1:0]                    size,
  output logic [ADDR_W-1:0]             dn_addr,
  output logic [$clog2(DATA_W)-1:0]     bus_pos
);
  localparam int POS_W  = $clog2(DATA_W);
  localparam int LANE_W = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] byte_addr;
  logic [ADDR_W-1:0] align_mask;
  logic [POS_W-1:0]  idx_full;
  logic [POS_W:0]    idx_lim;
  logic [POS_W-1:0]  idx;

  always_comb begin
    byte_addr  = tgt_base | ADDR_W'(offset >> 5);
    align_mask = ~((ADDR_W'(1) << size) - ADDR_W'(1));
    dn_addr    = byte_addr & align_mask;
    idx_full   = offset[POS_W+1:2];
    idx_lim    = (POS_W+1)'(8) << size;
    idx        = idx_full & POS_W'(idx_lim - (POS_W+1)'(1));
    bus_pos    = {dn_addr[LANE_W-1:0], 3'b000} | idx;
  end
endmodule

// File: rtl/bb_bit_rmw.sv
module bb_bit_rmw #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         rdata,
  input  logic [$clog2(DATA_W)-1:0] pos,
  input  logic                      set_val,
  output logic                      bit_out,
  output logic [DATA_W-1:0]         new_word
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask     = DATA_W'(1) << pos;
    bit_out  = |(rdata & mask);
    new_word = set_val ? (rdata | mask) : (rdata & ~mask);
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SPAN_LOG2 = 25,
  parameter int WIN_CNT   = 2,
  parameter logic [WIN_CNT*ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [WIN_CNT*ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [1:0]        s_size,
  input  logic              s_we,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_rsp_valid,
  output logic              s_rsp_err,
  output logic [DATA_W-1:0] s_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata
);
  import bb_pkg::*;

  localparam int POS_W = $clog2(DATA_W);

  bb_state_e         state;
  logic              win_hit;
  logic              req_ok;
  logic [ADDR_W-1:0] tgt_base;
  logic [ADDR_W-1:0] map_addr;
  logic [POS_W-1:0]  map_pos;
  logic [POS_W-1:0]  pos_q;
  logic              wr_q;
  logic              val_q;
  logic              sel_bit;
  logic [DATA_W-1:0] mod_word;

  bb_win_decode #(
    .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .WIN_CNT(WIN_CNT),
    .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE)
  ) u_dec (
    .addr(s_addr), .hit(win_hit), .tgt_base(tgt_base)
  );

  bb_addr_map #(
    .ADDR_W(ADDR_W), .SPAN_LOG2(SPAN_LOG2), .DATA_W(DATA_W)
  ) u_map (
    .tgt_base(tgt_base), .offset(s_addr[SPAN_LOG2-1:0]), .size(s_size),
    .dn_addr(map_addr), .bus_pos(map_pos)
  );

  bb_bit_rmw #(.DATA_W(DATA_W)) u_rmw (
    .rdata(m_rdata), .pos(pos_q), .set_val(val_q),
    .bit_out(sel_bit), .new_word(mod_word)
  );

  assign req_ok  = win_hit && (s_size != SZ_RSVD);
  assign s_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      s_rsp_valid <= 1'b0;
      s_rsp_err   <= 1'b0;
      s_rdata     <= '0;
      m_valid     <= 1'b0;
      m_we        <= 1'b0;
      m_addr      <= '0;
      m_size      <= '0;
      m_wdata     <= '0;
      pos_q       <= '0;
      wr_q        <= 1'b0;
      val_q       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          s_rsp_valid <= 1'b0;
          if (s_valid) begin
            if (!req_ok) begin
              state       <= ST_RESP;
              s_rsp_valid <= 1'b1;
              s_rsp_err   <= 1'b1;
              s_rdata     <= '0;
            end else begin
              state   <= ST_RDWAIT;
              m_valid <= 1'b1;
              m_we    <= 1'b0;
              m_addr  <= map_addr;
              m_size  <= s_size;
              pos_q   <= map_pos;
              wr_q    <= s_we;
              val_q   <= s_wdata[0];
            end
          end
        end
        ST_RDWAIT: begin
          if (m_ready) begin
            if (wr_q) begin
              state   <= ST_WRWAIT;
              m_we    <= 1'b1;
              m_wdata <= mod_word;
            end else begin
              state       <= ST_RESP;
              m_valid     <= 1'b0;
              s_rsp_valid <= 1'b1;
              s_rsp_err   <= 1'b0;
              s_rdata     <= {{(DATA_W-1){1'b0}}, sel_bit};
            end
          end
        end
        ST_WRWAIT: begin
          if (m_ready) begin
            state       <= ST_RESP;
            m_valid     <= 1'b0;
            m_we        <= 1'b0;
            s_rsp_valid <= 1'b1;
            s_rsp_err   <= 1'b0;
            s_rdata     <= '0;
          end
        end
        default: begin
          s_rsp_valid <= 1'b0;
          state       <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_rsp_valid,
  input logic              s_rsp_err,
  input logic [DATA_W-1:0] s_rdata,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_we,
  input logic [ADDR_W-1:0] m_addr,
  input logic [1:0]        m_size
);
  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we)));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |=> !s_rsp_valid);

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_we) |-> (m_valid && $past(m_valid && m_ready && !m_we) && $stable(m_addr)));

  // R4
  read_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    s_rsp_valid |-> (s_rdata[DATA_W-1:1] == '0));

  // R8
  err_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rsp_valid && s_rsp_err) |-> (!m_valid && !$past(m_valid)));

  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_size != 2'd3));
endmodule

bind bitband_bridge bitband_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .s_rsp_valid(s_rsp_valid), .s_rsp_err(s_rsp_err), .s_rdata(s_rdata),
  .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we), .m_addr(m_addr), .m_size(m_size)
);

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        we;
    logic [31:0] wdata;
    logic [2:0]  lat;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{32'h2200_0000, 2'd0, 1'b0, 32'h0000_0000, 3'd0},
    '{32'h2200_001C, 2'd0, 1'b0, 32'h0000_0000, 3'd2},
    '{32'h2200_0020, 2'd0, 1'b1, 32'h0000_0001, 3'd1},
    '{32'h2200_0044, 2'd1, 1'b0, 32'h0000_0000, 3'd3},
    '{32'h4200_03FC, 2'd2, 1'b1, 32'h0000_0000, 3'd0},
    '{32'h4200_0100, 2'd2, 1'b0, 32'h0000_0000, 3'd1},
    '{32'h2200_0064, 2'd1, 1'b1, 32'h0000_0001, 3'd2},
    '{32'h4200_0010, 2'd0, 1'b1, 32'hFFFF_FFFE, 3'd4},
    '{32'h3000_0000, 2'd0, 1'b0, 32'h0000_0000, 3'd0},
    '{32'h2400_0000, 2'd2, 1'b1, 32'h0000_0001, 3'd0},
    '{32'h21FF_FFFC, 2'd0, 1'b0, 32'h0000_0000, 3'd0},
    '{32'h23FF_FFFC, 2'd2, 1'b0, 32'h0000_0000, 3'd1},
    '{32'h2200_0020, 2'd0, 1'b0, 32'h0000_0000, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_addr = '0;
  logic [1:0]  s_size = '0;
  logic        s_we = 1'b0;
  logic [31:0] s_wdata = '0;
  logic        s_rsp_valid;
  logic        s_rsp_err;
  logic [31:0] s_rdata;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic        m_we;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = '0;

  int tests = 0;
  int fails = 0;

  bitband_bridge i_bitband_bridge (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_size(s_size),
    .s_we(s_we), .s_wdata(s_wdata),
    .s_rsp_valid(s_rsp_valid), .s_rsp_err(s_rsp_err), .s_rdata(s_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // downstream memory model
  logic [31:0] mem [16];
  int          mem_lat = 0;
  int          wait_cnt = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          order_bad = 0;
  logic [31:0] first_addr = '0;
  logic [1:0]  first_size = '0;
  logic [31:0] wr_addr = '0;
  logic [1:0]  wr_size = '0;

  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      if (m_we) begin
        wr_cnt  = wr_cnt + 1;
        wr_addr = m_addr;
        wr_size = m_size;
        if (rd_cnt != 1) order_bad = order_bad + 1;
        for (int b = 0; b < 4; b++) begin
          if ((m_size == 2'd2) || (m_size == 2'd1 && (b >> 1) == int'(m_addr[1])) ||
              (m_size == 2'd0 && b == int'(m_addr[1:0])))
            mem[m_addr[5:2]][b*8 +: 8] = m_wdata[b*8 +: 8];
        end
      end else begin
        if (rd_cnt == 0) begin
          first_addr = m_addr;
          first_size = m_size;
        end
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (m_ready) begin
      m_ready  = 1'b0;
      wait_cnt = 0;
    end else if (m_valid) begin
      if (wait_cnt >= mem_lat) begin
        m_ready = 1'b1;
        m_rdata = mem[m_addr[5:2]];
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected mapping from the requirement text
  task automatic ref_map(input logic [31:0] a, input logic [1:0] sz, output bit hit,
                         output logic [31:0] da, output int pos);
    logic [31:0] tb;
    int idx;
    hit = 1'b1;
    if (a[31:25] == 7'h11) tb = 32'h2000_0000;
    else if (a[31:25] == 7'h21) tb = 32'h4000_0000;
    else begin hit = 1'b0; tb = '0; end
    if (sz == 2'd3) hit = 1'b0;
    da = tb | {12'h0, a[24:5]};
    if (sz == 2'd1) da[0] = 1'b0;
    if (sz == 2'd2) da[1:0] = 2'b00;
    idx = int'(a[6:2]);
    if (sz == 2'd0) idx = idx % 8;
    else if (sz == 2'd1) idx = idx % 16;
    pos = int'(da[1:0]) * 8 + idx;
  endtask

  task automatic run_vec(input vec_t v);
    bit          hit;
    logic [31:0] da;
    int          pos;
    logic [31:0] old_w;
    logic [31:0] exp_w;
    int          busy_bad;
    bit          got;
    ref_map(v.addr, v.size, hit, da, pos);
    old_w = mem[da[5:2]];
    exp_w = old_w;
    exp_w[pos] = v.wdata[0];
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; order_bad = 0;
    mem_lat = int'(v.lat);
    s_valid = 1'b1; s_addr = v.addr; s_size = v.size; s_we = v.we; s_wdata = v.wdata;
    @(negedge clk);
    s_valid = 1'b0;
    busy_bad = 0;
    got = 1'b0;
    for (int n = 0; n < 64; n++) begin
      if (s_rsp_valid) begin got = 1'b1; break; end
      if (s_ready) busy_bad++;
      @(negedge clk);
    end
    check(got, "R7 response seen", {31'h0, got}, 32'h1);
    check(busy_bad == 0, "R7 s_ready low while busy", busy_bad, 0);
    check(s_rsp_err == !hit, "R1/R8 error flag", {31'h0, s_rsp_err}, {31'h0, !hit});
    if (!hit) begin
      check(rd_cnt == 0 && wr_cnt == 0, "R8 no downstream access", rd_cnt + wr_cnt, 0);
      check(s_rdata == 0, "R8 rdata zero", s_rdata, 0);
    end else begin
      check(first_addr == da, "R2 downstream address", first_addr, da);
      check(first_size == v.size, "R2 downstream size", {30'h0, first_size}, {30'h0, v.size});
      if (v.we) begin
        check(rd_cnt == 1 && wr_cnt == 1 && order_bad == 0, "R6 read then write",
              rd_cnt * 16 + wr_cnt, 32'h11);
        check(wr_addr == da && wr_size == v.size, "R6 write same address", wr_addr, da);
        check(mem[da[5:2]] == exp_w, "R5/R3 memory after write", mem[da[5:2]], exp_w);
      end else begin
        check(rd_cnt == 1 && wr_cnt == 0, "R4 single read", rd_cnt * 16 + wr_cnt, 32'h10);
        check(s_rdata == {31'h0, old_w[pos]}, "R4/R3 read bit", s_rdata, {31'h0, old_w[pos]});
      end
    end
    @(negedge clk);
    check(!s_rsp_valid && s_ready, "R7 one-cycle response", {30'h0, s_rsp_valid, s_ready}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5C3_0F96 ^ (32'h1357_9BDF * i);
    repeat (3) @(negedge clk);
    // R9 reset state
    check(s_ready == 1'b1, "R9 s_ready after reset", {31'h0, s_ready}, 1);
    check(m_valid == 1'b0, "R9 m_valid after reset", {31'h0, m_valid}, 0);
    check(s_rsp_valid == 1'b0, "R9 rsp after reset", {31'h0, s_rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

    // R5 directed: byte 1 bit 3 forced to 1, then cleared with upper data bits set
    mem[0] = 32'h0000_0000;
    run_vec('{32'h2200_002C, 2'd0, 1'b1, 32'h0000_0001, 3'd2});
    check(mem[0] == 32'h0000_0800, "R5 set bit 11", mem[0], 32'h0000_0800);
    run_vec('{32'h2200_002C, 2'd0, 1'b1, 32'hFFFF_FFFE, 3'd0});
    check(mem[0] == 32'h0000_0000, "R5 clear ignores upper data", mem[0], 0);

    // R10 directed: long wait, address and request held
    @(negedge clk);
    mem_lat = 6;
    s_valid = 1'b1; s_addr = 32'h4200_0084; s_size = 2'd2; s_we = 1'b0;
    @(negedge clk);
    s_valid = 1'b0;
    begin
      int hold_bad = 0;
      for (int n = 0; n < 5; n++) begin
        if (!m_valid || m_addr != 32'h4000_0004 || m_we) hold_bad++;
        @(negedge clk);
      end
      check(hold_bad == 0, "R10 request held during wait", hold_bad, 0);
    end
    for (int n = 0; n < 20 && !s_rsp_valid; n++) @(negedge clk);
    check(s_rsp_valid && !s_rsp_err, "R10 response after long wait", {30'h0, s_rsp_valid, s_rsp_err}, 32'h2);
    @(negedge clk);

    // R8 reserved size code inside a window
    run_vec('{32'h2200_0000, 2'd3, 1'b0, 32'h0000_0000, 3'd0});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule